// File: doc/BRIEF.md
# NAND Asynchronous Bus Cycle Timer

This block turns single bus requests into asynchronous NAND strobe cycles. A request is presented for one clock with a read/write flag, a transfer kind (command, address or data) and a write byte. The block then drives chip enable, the command and address latch enables, the write and read strobes and the output enable of the data bus. Every phase is timed by 8-bit tick counts taken from two 32-bit timing words. A read returns the byte sampled from the bus, and every access ends with a one-cycle done pulse.

The write strobe low time is not a field of its own. It is derived as the write cycle length minus the write-strobe high length. The package also holds pure functions that convert nanosecond datasheet parameters into ticks and pack them into the two timing words. Those functions are meant for configuration code and for testbenches.

Top module: `nct_cycle_timer`

## Requirements
- R1: After reset, busy and done are 0, ce_n, we_n and re_n are 1, and dq_oe, cle and ale are 0.
- R2: Write timing word fields are: [31:24] setup ticks (chip enable low before any strobe), [23:16] post-command extension, [15:8] write cycle length, [7:0] write-strobe high length. Read timing word fields are: [31:24] sample delay, [23:16] read-strobe high hold, [15:8] read-strobe low length, [7:0] bus release.
- R3: Every phase lasts at least one tick, so a field value of 0 acts as 1. The write-strobe low phase lasts (cycle - high) ticks, or 1 tick when cycle is not greater than high.
- R4: A write runs setup, then we_n low for the write-low count, then we_n high for the write-high count. dq_oe is 1 and dq_out equals the request byte throughout both strobe phases and at no other time.
- R5: Kind encoding is 2'b01 command, 2'b10 address, 2'b00 or 2'b11 data. cle is high for the whole access of a command, ale for the whole access of an address, and neither for data. Only a command write appends the extension phase, with chip enable low and strobes high.
- R6: A read runs setup, then re_n low for the read-low count, then re_n high for the hold count, then the release count. dq_oe stays 0 for the whole read.
- R7: Read data is sampled at the end of tick min(sample delay, read-low) of the re_n low phase, counting from 1, and rdata holds that byte until the next read.
- R8: Busy rises the cycle after an accepted request. done is a single-cycle pulse in the cycle after the last phase tick, and busy is 0 in that cycle, so busy lasts exactly the sum of the phase lengths.
- R9: A request presented while busy is 1 is ignored: the access in flight keeps its timing and no further access follows.
- R10: ns_to_ticks(kHz, ps) returns ceil(kHz * ps / 1e9). The packers put setup = ticks(tCEA - tREA), extension = ticks(tWB), cycle = ticks(tWC), write-high = ticks(tWC - tWP), sample = ticks(tREA), hold = ticks(tREH), read-low = ticks(tRC - tREH) and release = ticks(tRHZ).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmg_wr | input | 32 | Write timing word, held stable while busy |
| tmg_rd | input | 32 | Read timing word, held stable while busy |
| req_valid | input | 1 | One-cycle access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_kind | input | 2 | Transfer kind (see R5) |
| req_wdata | input | 8 | Byte to write |
| dq_in | input | 8 | Data bus input from the flash |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rdata | output | 8 | Last byte read |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_oe | output | 1 | Data bus output enable |
| dq_out | output | 8 | Data bus output value |

## Verification
The bench keeps the default 8-bit counts but fills every timing field with the values 0 to 3 only. This covers every kind with every setup, cycle, high and extension combination for writes, and every setup, sample, low, hold and release combination for reads. In that range the zero-as-one rule, the clamped write-low difference, and sample delays both shorter and longer than the read-low phase are all reached. The flash model returns a byte that encodes its position in the re_n low phase, which exposes the exact sampling tick. Some accesses carry a second request mid-access, and fixed nanosecond values exercise the tick conversion and word packing.

// File: rtl/nct_pkg.sv
// Shared types, widths and configuration helpers for the NAND cycle timer.
// Assumes 8-bit tick fields, four per 32-bit timing word.
package nct_pkg;

    localparam int CNT_W  = 8;
    localparam int WORD_W = 4 * CNT_W;

    typedef enum logic [1:0] {
        KIND_DATA = 2'b00,
        KIND_CMD  = 2'b01,
        KIND_ADDR = 2'b10,
        KIND_ALT  = 2'b11
    } bus_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_SETUP, PH_WLOW, PH_WHIGH, PH_WEXT, PH_RLOW, PH_RHIGH, PH_RREL
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] wlow;
        logic [CNT_W-1:0] whigh;
        logic [CNT_W-1:0] wext;
        logic [CNT_W-1:0] samp;
        logic [CNT_W-1:0] rlow;
        logic [CNT_W-1:0] rhigh;
        logic [CNT_W-1:0] rrel;
    } phase_lens_t;

    // Ceiling conversion of picoseconds to clock ticks at a given kHz rate.
    function automatic longint unsigned ns_to_ticks(input longint unsigned khz,
                                                    input longint unsigned ps);
        return (khz * ps + 64'd999_999_999) / 64'd1_000_000_000;
    endfunction

    function automatic logic [CNT_W-1:0] sat_cnt(input longint unsigned v);
        return (v > ((1 << CNT_W) - 1)) ? CNT_W'((1 << CNT_W) - 1) : CNT_W'(v);
    endfunction

    function automatic longint unsigned ps_diff(input longint unsigned a,
                                                input longint unsigned b);
        return (a > b) ? a - b : 64'd0;
    endfunction

    // Pack the write timing word from datasheet picosecond values.
    function automatic logic [WORD_W-1:0] pack_wr_word(
        input longint unsigned khz, input longint unsigned t_cea,
        input longint unsigned t_rea, input longint unsigned t_wb,
        input longint unsigned t_wc, input longint unsigned t_wp);
        return {sat_cnt(ns_to_ticks(khz, ps_diff(t_cea, t_rea))),
                sat_cnt(ns_to_ticks(khz, t_wb)),
                sat_cnt(ns_to_ticks(khz, t_wc)),
                sat_cnt(ns_to_ticks(khz, ps_diff(t_wc, t_wp)))};
    endfunction

    // Pack the read timing word from datasheet picosecond values.
    function automatic logic [WORD_W-1:0] pack_rd_word(
        input longint unsigned khz, input longint unsigned t_rea,
        input longint unsigned t_reh, input longint unsigned t_rc,
        input longint unsigned t_rhz);
        return {sat_cnt(ns_to_ticks(khz, t_rea)),
                sat_cnt(ns_to_ticks(khz, t_reh)),
                sat_cnt(ns_to_ticks(khz, ps_diff(t_rc, t_reh))),
                sat_cnt(ns_to_ticks(khz, t_rhz))};
    endfunction

endpackage

// File: rtl/nct_cfg_decode.sv
// Unpacks the two timing words into effective phase lengths.
// Assumes: every length is forced to at least one tick; write-low is the
// cycle length minus the write-high length, floored at one.
module nct_cfg_decode
    import nct_pkg::*;
(
    input  logic [WORD_W-1:0] tmg_wr,
    input  logic [WORD_W-1:0] tmg_rd,
    output phase_lens_t       lens
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    logic [CNT_W-1:0] f_setup, f_ext, f_cyc, f_high;
    logic [CNT_W-1:0] f_samp, f_hold, f_rlow, f_rel;
    logic [CNT_W-1:0] cyc_minus_high;

    // Field slicing and difference for the write-low phase.
    always_comb begin
        {f_setup, f_ext, f_cyc, f_high} = tmg_wr;
        {f_samp, f_hold, f_rlow, f_rel} = tmg_rd;
        cyc_minus_high = (f_cyc > f_high) ? (f_cyc - f_high) : '0;
        lens.setup = at_least_one(f_setup);
        lens.wlow  = at_least_one(cyc_minus_high);
        lens.whigh = at_least_one(f_high);
        lens.wext  = at_least_one(f_ext);
        lens.samp  = at_least_one(f_samp);
        lens.rlow  = at_least_one(f_rlow);
        lens.rhigh = at_least_one(f_hold);
        lens.rrel  = at_least_one(f_rel);
    end
endmodule

// File: rtl/nct_phase_cnt.sv
// Elapsed-tick counter for the current phase; cleared on every phase change.
// Assumes len >= 1 while counting.
module nct_phase_cnt
    import nct_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] len,
    output logic [CNT_W-1:0] elapsed,
    output logic             last
);
    // Count ticks spent in the phase, restart at zero when cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) elapsed <= '0;
        else                 elapsed <= elapsed + CNT_W'(1);
    end

    // Final tick of the phase.
    always_comb last = (elapsed == (len - CNT_W'(1)));
endmodule

// File: rtl/nct_strobe_gen.sv
// Decodes the registered phase and latched request into bus pin levels.
// Assumes phase and kind come straight from flops, so pins change only at edges.
module nct_strobe_gen
    import nct_pkg::*;
(
    input  phase_e     phase,
    input  bus_kind_e  kind,
    input  logic [7:0] wbyte,
    output logic       ce_n,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic       dq_oe,
    output logic [7:0] dq_out
);
    logic active;

    // Pin decode from the current phase.
    always_comb begin
        active = (phase != PH_IDLE);
        ce_n   = !active;
        cle    = active && (kind == KIND_CMD);
        ale    = active && (kind == KIND_ADDR);
        we_n   = (phase != PH_WLOW);
        re_n   = (phase != PH_RLOW);
        dq_oe  = (phase == PH_WLOW) || (phase == PH_WHIGH);
        dq_out = wbyte;
    end
endmodule

// File: rtl/nct_cycle_timer.sv
// NAND asynchronous bus cycle timer: sequences one access per request through
// setup, strobe and recovery phases timed by two packed timing words.
// Assumes timing words are stable while busy; requests while busy are dropped.
module nct_cycle_timer
    import nct_pkg::*;
#(
    parameter int TW = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tmg_wr,
    input  logic [TW-1:0] tmg_rd,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [1:0]    req_kind,
    input  logic [7:0]    req_wdata,
    input  logic [7:0]    dq_in,
    output logic          busy,
    output logic          done,
    output logic [7:0]    rdata,
    output logic          ce_n,
    output logic          cle,
    output logic          ale,
    output logic          we_n,
    output logic          re_n,
    output logic          dq_oe,
    output logic [7:0]    dq_out
);
    phase_lens_t      lens;
    phase_e           phase, phase_nx;
    bus_kind_e        kind_q;
    logic             write_q;
    logic [7:0]       wbyte_q;
    logic [CNT_W-1:0] cur_len, elapsed, samp_idx;
    logic             last, accept, finish;

    nct_cfg_decode u_dec (
        .tmg_wr (tmg_wr[WORD_W-1:0]),
        .tmg_rd (tmg_rd[WORD_W-1:0]),
        .lens   (lens)
    );

    // Length of the phase currently running.
    always_comb begin
        unique case (phase)
            PH_SETUP: cur_len = lens.setup;
            PH_WLOW:  cur_len = lens.wlow;
            PH_WHIGH: cur_len = lens.whigh;
            PH_WEXT:  cur_len = lens.wext;
            PH_RLOW:  cur_len = lens.rlow;
            PH_RHIGH: cur_len = lens.rhigh;
            PH_RREL:  cur_len = lens.rrel;
            default:  cur_len = CNT_W'(1);
        endcase
    end

    nct_phase_cnt u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   ((phase == PH_IDLE) || last),
        .len     (cur_len),
        .elapsed (elapsed),
        .last    (last)
    );

    // Next-phase selection.
    always_comb begin
        accept   = (phase == PH_IDLE) && req_valid;
        phase_nx = phase;
        finish   = 1'b0;
        unique case (phase)
            PH_IDLE:  if (req_valid) phase_nx = PH_SETUP;
            PH_SETUP: if (last) phase_nx = write_q ? PH_WLOW : PH_RLOW;
            PH_WLOW:  if (last) phase_nx = PH_WHIGH;
            PH_WHIGH: if (last) begin
                if (kind_q == KIND_CMD) phase_nx = PH_WEXT;
                else begin phase_nx = PH_IDLE; finish = 1'b1; end
            end
            PH_WEXT:  if (last) begin phase_nx = PH_IDLE; finish = 1'b1; end
            PH_RLOW:  if (last) phase_nx = PH_RHIGH;
            PH_RHIGH: if (last) phase_nx = PH_RREL;
            PH_RREL:  if (last) begin phase_nx = PH_IDLE; finish = 1'b1; end
            default:  phase_nx = PH_IDLE;
        endcase
    end

    // Phase register and end-of-access pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            done  <= 1'b0;
        end else begin
            phase <= phase_nx;
            done  <= finish;
        end
    end

    // Latch the request fields on acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            kind_q  <= KIND_DATA;
            wbyte_q <= '0;
        end else if (accept) begin
            write_q <= req_write;
            kind_q  <= bus_kind_e'(req_kind);
            wbyte_q <= req_wdata;
        end
    end

    // Zero-based sampling tick inside the read-low phase.
    always_comb samp_idx = ((lens.samp < lens.rlow) ? lens.samp : lens.rlow) - CNT_W'(1);

    // Capture the data bus at the sampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     rdata <= '0;
        else if (phase == PH_RLOW && elapsed == samp_idx) rdata <= dq_in;
    end

    always_comb busy = (phase != PH_IDLE);

    nct_strobe_gen u_pins (
        .phase  (phase),
        .kind   (kind_q),
        .wbyte  (wbyte_q),
        .ce_n   (ce_n),
        .cle    (cle),
        .ale    (ale),
        .we_n   (we_n),
        .re_n   (re_n),
        .dq_oe  (dq_oe),
        .dq_out (dq_out)
    );
endmodule

// File: rtl/nct_checker.sv
// Protocol checks on the cycle timer pins, attached by bind.
module nct_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic ce_n,
    input logic cle,
    input logic ale,
    input logic we_n,
    input logic re_n,
    input logic dq_oe
);
    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    // R6
    oe_off_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !dq_oe);
    // R5
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R9
    start_by_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
    // R4
    strobe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n || dq_oe) |-> !ce_n);
endmodule

bind nct_cycle_timer nct_checker u_nct_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .ce_n      (ce_n),
    .cle       (cle),
    .ale       (ale),
    .we_n      (we_n),
    .re_n      (re_n),
    .dq_oe     (dq_oe)
);

// File: tb/nct_cycle_timer_tb.sv
module nct_cycle_timer_tb_top;
    import nct_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tmg_wr = '0, tmg_rd = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [7:0]  req_wdata = '0, dq_in = 8'h5F;
    logic        busy, done, ce_n, cle, ale, we_n, re_n, dq_oe;
    logic [7:0]  rdata, dq_out;

    int checks = 0, failures = 0, cycles = 0, lowcnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nct_cycle_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tmg_wr(tmg_wr), .tmg_rd(tmg_rd),
        .req_valid(req_valid), .req_write(req_write), .req_kind(req_kind),
        .req_wdata(req_wdata), .dq_in(dq_in), .busy(busy), .done(done),
        .rdata(rdata), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .dq_oe(dq_oe), .dq_out(dq_out)
    );

    // Flash model: byte encodes the position inside the read-low phase.
    always @(negedge clk) begin
        if (!re_n) begin
            lowcnt = lowcnt + 1;
            dq_in  = 8'hA0 | 8'(lowcnt);
        end else begin
            lowcnt = 0;
            dq_in  = 8'h5F;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_LIMIT) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WDOG_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic int e1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Run one access from just after a negedge; optionally inject a second request.
    task automatic run_access(input bit wr, input logic [1:0] kind, input logic [7:0] wb,
                              input int f_setup, input int f_ext, input int f_cyc, input int f_high,
                              input int f_samp, input int f_hold, input int f_rlow, input int f_rel,
                              input bit inject);
        int n_busy = 0, n_we = 0, n_re = 0, n_oe = 0, n_cle = 0, n_ale = 0, bad_dq = 0, guard = 0;
        int exp_total, exp_wlow, exp_oe, is_cmd, is_addr, samp;
        bit seen_done = 0;
        tmg_wr    = {8'(f_setup), 8'(f_ext), 8'(f_cyc), 8'(f_high)};
        tmg_rd    = {8'(f_samp), 8'(f_hold), 8'(f_rlow), 8'(f_rel)};
        req_write = wr; req_kind = kind; req_wdata = wb; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!seen_done && guard < 600) begin
            if (done) seen_done = 1;
            else begin
                if (busy) n_busy++;
                if (!we_n) n_we++;
                if (!re_n) n_re++;
                if (cle) n_cle++;
                if (ale) n_ale++;
                if (dq_oe) begin n_oe++; if (dq_out != wb) bad_dq++; end
                req_valid = inject && (n_busy == 2);
                req_write = ~wr; req_kind = KIND_CMD; req_wdata = ~wb;
                @(negedge clk);
                guard++;
            end
        end
        req_valid = 1'b0;
        is_cmd  = (kind == 2'b01);
        is_addr = (kind == 2'b10);
        exp_wlow = e1((f_cyc > f_high) ? f_cyc - f_high : 0);
        if (wr) begin
            exp_total = e1(f_setup) + exp_wlow + e1(f_high) + (is_cmd ? e1(f_ext) : 0);
            exp_oe = exp_wlow + e1(f_high);
        end else begin
            exp_total = e1(f_setup) + e1(f_rlow) + e1(f_hold) + e1(f_rel);
            exp_oe = 0;
        end
        chk(seen_done, "R8 done seen", seen_done, 1);
        chk(n_busy == exp_total, "R8 busy length", n_busy, exp_total);
        chk(busy == 1'b0, "R8 idle at done", busy, 0);
        chk(n_cle == (is_cmd ? exp_total : 0), "R5 cle span", n_cle, is_cmd ? exp_total : 0);
        chk(n_ale == (is_addr ? exp_total : 0), "R5 ale span", n_ale, is_addr ? exp_total : 0);
        chk(n_oe == exp_oe, "R4 R6 output enable span", n_oe, exp_oe);
        chk(bad_dq == 0, "R4 write data", bad_dq, 0);
        if (wr) begin
            chk(n_we == exp_wlow, "R3 R4 we_n low ticks", n_we, exp_wlow);
            chk(n_re == 0, "R4 re_n idle", n_re, 0);
        end else begin
            samp = (e1(f_samp) < e1(f_rlow)) ? e1(f_samp) : e1(f_rlow);
            chk(n_re == e1(f_rlow), "R6 re_n low ticks", n_re, e1(f_rlow));
            chk(n_we == 0, "R6 we_n idle", n_we, 0);
            chk(rdata == (8'hA0 | 8'(samp)), "R7 sample tick", rdata, 8'hA0 | 8'(samp));
        end
        @(negedge clk);
        chk(!done && !busy, "R8 R9 quiet after done", {done, busy}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && ce_n && we_n && re_n && !dq_oe && !cle && !ale,
            "R1 reset state", {busy, done, ce_n, we_n, re_n, dq_oe, cle, ale}, 8'b0011_1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && ce_n, "R1 idle after reset", busy, 0);

        // R10 conversion and packing at 100 MHz
        chk(ns_to_ticks(100000, 25000) == 3, "R10 round up", ns_to_ticks(100000, 25000), 3);
        chk(ns_to_ticks(100000, 20000) == 2, "R10 exact", ns_to_ticks(100000, 20000), 2);
        chk(ns_to_ticks(100000, 0) == 0, "R10 zero", ns_to_ticks(100000, 0), 0);
        chk(pack_wr_word(100000, 45000, 20000, 100000, 25000, 12000) == 32'h030A0302,
            "R10 write word", pack_wr_word(100000, 45000, 20000, 100000, 25000, 12000), 32'h030A0302);
        chk(pack_rd_word(100000, 20000, 10000, 25000, 100000) == 32'h0201020A,
            "R10 read word", pack_rd_word(100000, 20000, 10000, 25000, 100000), 32'h0201020A);

        // R2 R3 R4 R5 R9 write sweep over every kind and field value 0..3
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++)
                    for (int c = 0; c < 4; c++)
                        for (int d = 0; d < 4; d++)
                            run_access(1'b1, 2'(k), 8'(17*a + 5*b + 3*c + d + 16*k), a, b, c, d,
                                       3, 3, 3, 3, ((a + c + d) % 3) == 0);

        // R2 R6 R7 R9 read sweep: setup, sample, hold, low, release each 0..3
        for (int a = 0; a < 4; a++)
            for (int s = 0; s < 4; s++)
                for (int h = 0; h < 4; h++)
                    for (int l = 0; l < 4; l++)
                        for (int r = 0; r < 4; r++)
                            run_access(1'b0, (s == 3) ? 2'b10 : 2'b00, 8'h00, a, 3, 3, 1,
                                       s, h, l, r, ((s + l + r) % 4) == 1);

        // R2 large-field spot checks in the upper byte lanes
        run_access(1'b1, 2'b01, 8'hC3, 9, 7, 20, 4, 0, 0, 0, 0, 1'b1);
        run_access(1'b0, 2'b00, 8'h00, 5, 0, 0, 0, 6, 8, 11, 9, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule